// File: doc/BRIEF.md
# Protected Flash Program/Erase Controller

This block is a nonvolatile memory controller that sits on a CPU register bus in front of a small on-chip flash array, held here as internal storage. Software reaches it through five register selects: a control word, a key register, a page pointer, an in-page offset pointer and a data window. Writes to the data window load a one-row write buffer. Reads from the data window return the array word at the address formed from the page and the offset.

An erase or program cycle starts only under three conditions. The unlock key must be written in two consecutive bus writes. The control word must then be written with its start and write-enable bits set. The operation field must name a supported operation. While the cycle runs the controller holds a stall output high for a parameterised number of clocks and ignores the bus. When the cycle ends it commits the change to the array and clears the start bit itself. Block erase sets an eight-row block to all ones. Row program copies the buffer into one row and then returns the buffer to all ones.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000, stall_o is low, and every array location reads 0xFFFF through the data window (select 4).
- R2: A control write (select 0) with bit 15 (start) and bit 6 (write enable) set starts a cycle only if the two bus writes just before it were a key write (select 1) of low byte 0x55 and then a key write of low byte 0xAA. stall_o is high from the next cycle on, and bit 15 reads 1 while the cycle runs.
- R3: A wrong key byte, the two key bytes in reversed order, a repeated 0x55, or any other bus write between 0xAA and the control write cancels the unlock. The following start request is then ignored: stall_o stays low and bit 15 reads 0.
- R4: A start request with bit 6 clear is ignored, even after a valid unlock.
- R5: stall_o stays high for exactly ERASE_CYCLES clocks for a block erase and for exactly PROG_CYCLES clocks for a row program. Bit 15 reads 0 once stall_o falls.
- R6: Operation code 4'b0001 in bits [3:0], with bit 14 clear, programs the buffer into the 64-word row selected by the address bits above the low six. The low six offset bits play no part in choosing the row.
- R7: Operation code 4'b0010 with bit 14 set writes 0xFFFF to all 512 words of the eight-row block that holds the address. Words outside that block keep their values.
- R8: An unlocked, write-enabled start with any other code or bit 14 combination sets the fault flag (bit 13) and starts nothing. The flag holds until the next valid start clears it.
- R9: After a row program completes, the write buffer holds all ones. Programming the same row again with no new buffer writes leaves it at 0xFFFF.
- R10: Every bus write that arrives while stall_o is high is ignored, including one that arrives in the last stalled cycle.
- R11: A write to the data window stores the word into buffer slot offset[5:0]. The array address is {page[1:0], offset[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select: 0 control, 1 key, 2 page, 3 offset, 4 data window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| stall_o | output | 1 | High while an erase or program cycle runs |

## Verification
Two events can land on the same clock edge: the commit at the end of a cycle, which clears the start bit and writes the array, and a bus write issued in the last stalled cycle. The bench provokes this by counting exactly ERASE_CYCLES-1 falling edges after the start. It then drives a page write so that the write lands on the same edge that ends the erase. Correct behaviour is that the page register keeps its old value, the erase takes effect, and an identical page write one cycle later is accepted.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int BUS_W = 16;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam logic [3:0] OP_BLK_ERASE = 4'b0010;
    localparam logic [3:0] OP_ROW_PROG  = 4'b0001;

    localparam int BIT_START = 15;
    localparam int BIT_ERASE = 14;
    localparam int BIT_FAULT = 13;
    localparam int BIT_WEN   = 6;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_KEY  = 3'd1,
        SEL_PAGE = 3'd2,
        SEL_OFFS = 3'd3,
        SEL_DATA = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    typedef struct packed {
        logic       start;
        logic       erase;
        logic       fault;
        logic       wen;
        logic [3:0] op;
    } ctrl_t;
endpackage

// File: rtl/nvm_key_unlock.sv
module nvm_key_unlock
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       key_sel,
    input  logic [7:0] key_byte,
    output logic       armed
);
    key_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (key_sel && key_byte == KEY_FIRST && st_q == KEY_IDLE)
                st_d = KEY_HALF;
            else if (key_sel && key_byte == KEY_SECOND && st_q == KEY_HALF)
                st_d = KEY_ARMED;
            else
                st_d = KEY_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == KEY_ARMED);

    // R2
    armed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == KEY_ARMED) |-> $past(wr_en && key_sel && key_byte == KEY_SECOND));
endmodule

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
    parameter int ERASE_CYCLES = 40,
    parameter int PROG_CYCLES  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_erase,
    input  logic go_prog,
    output logic busy,
    output logic done,
    output logic commit_erase,
    output logic commit_prog
);
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic             busy;
        logic             kind_erase;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == CNT_W'(1)) begin
                t_d.busy = 1'b0;
                t_d.cnt  = '0;
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end else if (go_erase) begin
            t_d.busy       = 1'b1;
            t_d.kind_erase = 1'b1;
            t_d.cnt        = CNT_W'(ERASE_CYCLES);
        end else if (go_prog) begin
            t_d.busy       = 1'b1;
            t_d.kind_erase = 1'b0;
            t_d.cnt        = CNT_W'(PROG_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy         = t_q.busy;
    assign done         = t_q.busy && (t_q.cnt == CNT_W'(1));
    assign commit_erase = done && t_q.kind_erase;
    assign commit_prog  = done && !t_q.kind_erase;

    // R5
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.busy |-> (t_q.cnt != '0));

    // R5
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.busy) |-> (t_q.cnt == (t_q.kind_erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES))));
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int PAGE_W    = 2,
    parameter int OFF_W     = 8,
    parameter int ROW_W     = 6,
    parameter int BLK_ROW_W = 3,
    parameter int DATA_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lat_we,
    input  logic [ROW_W-1:0]            lat_idx,
    input  logic [DATA_W-1:0]           lat_data,
    input  logic                        erase_go,
    input  logic                        prog_go,
    input  logic [PAGE_W+OFF_W-1:0]     addr,
    output logic [DATA_W-1:0]           rdata
);
    localparam int ADDR_W    = PAGE_W + OFF_W;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int ROW_WORDS = 1 << ROW_W;
    localparam int BLK_W     = ROW_W + BLK_ROW_W;
    localparam int BLK_WORDS = 1 << BLK_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] lat_q [ROW_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (erase_go) begin
            for (int i = 0; i < BLK_WORDS; i++)
                mem_q[{addr[ADDR_W-1:BLK_W], BLK_W'(i)}] <= '1;
        end else if (prog_go) begin
            for (int i = 0; i < ROW_WORDS; i++)
                mem_q[{addr[ADDR_W-1:ROW_W], ROW_W'(i)}] <= lat_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROW_WORDS; i++) lat_q[i] <= '1;
        end else if (prog_go) begin
            for (int i = 0; i < ROW_WORDS; i++) lat_q[i] <= '1;
        end else if (lat_we) begin
            lat_q[lat_idx] <= lat_data;
        end
    end

    assign rdata = mem_q[addr];

    // R9
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> (lat_q[0] == '1) && (lat_q[ROW_WORDS-1] == '1));
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
    import nvm_pkg::*;
#(
    parameter int PAGE_W       = 2,
    parameter int OFF_W        = 8,
    parameter int ROW_W        = 6,
    parameter int BLK_ROW_W    = 3,
    parameter int ERASE_CYCLES = 40,
    parameter int PROG_CYCLES  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [2:0]       bus_sel,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             stall_o
);
    localparam int ADDR_W = PAGE_W + OFF_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [BUS_W-1:0] page;
        logic [BUS_W-1:0] offs;
    } regs_t;

    regs_t r_d, r_q;

    logic busy, done, commit_erase, commit_prog, armed;
    logic acc_wr, sel_ctrl, start_req, op_erase, op_prog;
    logic go_erase, go_prog, bad_start;
    logic [BUS_W-1:0]  arr_rdata;
    logic [ADDR_W-1:0] flat_addr;

    assign acc_wr    = bus_wr && !busy;
    assign flat_addr = {r_q.page[PAGE_W-1:0], r_q.offs[OFF_W-1:0]};

    always_comb begin
        r_d       = r_q;
        sel_ctrl  = acc_wr && (bus_sel == SEL_CTRL);
        start_req = sel_ctrl && armed && bus_wdata[BIT_START] && bus_wdata[BIT_WEN];
        op_erase  = (bus_wdata[3:0] == OP_BLK_ERASE) && bus_wdata[BIT_ERASE];
        op_prog   = (bus_wdata[3:0] == OP_ROW_PROG) && !bus_wdata[BIT_ERASE];
        go_erase  = start_req && op_erase;
        go_prog   = start_req && op_prog;
        bad_start = start_req && !op_erase && !op_prog;

        if (sel_ctrl) begin
            r_d.ctrl.erase = bus_wdata[BIT_ERASE];
            r_d.ctrl.wen   = bus_wdata[BIT_WEN];
            r_d.ctrl.op    = bus_wdata[3:0];
            r_d.ctrl.start = go_erase || go_prog;
            if (go_erase || go_prog) r_d.ctrl.fault = 1'b0;
            else if (bad_start)      r_d.ctrl.fault = 1'b1;
        end
        if (done) r_d.ctrl.start = 1'b0;

        if (acc_wr && bus_sel == SEL_PAGE) r_d.page = bus_wdata;
        if (acc_wr && bus_sel == SEL_OFFS) r_d.offs = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    nvm_key_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_wr),
        .key_sel  (bus_sel == SEL_KEY),
        .key_byte (bus_wdata[7:0]),
        .armed    (armed)
    );

    nvm_cycle_timer #(
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROG_CYCLES  (PROG_CYCLES)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_erase     (go_erase),
        .go_prog      (go_prog),
        .busy         (busy),
        .done         (done),
        .commit_erase (commit_erase),
        .commit_prog  (commit_prog)
    );

    nvm_store #(
        .PAGE_W    (PAGE_W),
        .OFF_W     (OFF_W),
        .ROW_W     (ROW_W),
        .BLK_ROW_W (BLK_ROW_W),
        .DATA_W    (BUS_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_we   (acc_wr && bus_sel == SEL_DATA),
        .lat_idx  (r_q.offs[ROW_W-1:0]),
        .lat_data (bus_wdata),
        .erase_go (commit_erase),
        .prog_go  (commit_prog),
        .addr     (flat_addr),
        .rdata    (arr_rdata)
    );

    always_comb begin
        case (bus_sel)
            SEL_CTRL: bus_rdata = {r_q.ctrl.start, r_q.ctrl.erase, r_q.ctrl.fault, 6'b0,
                                   r_q.ctrl.wen, 2'b0, r_q.ctrl.op};
            SEL_PAGE: bus_rdata = r_q.page;
            SEL_OFFS: bus_rdata = r_q.offs;
            SEL_DATA: bus_rdata = arr_rdata;
            default:  bus_rdata = '0;
        endcase
    end

    assign stall_o = busy;

    // R2
    start_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_erase || go_prog) |=> stall_o);

    // R5
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !r_q.ctrl.start);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> r_q.ctrl.start);

    // R8
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_start |=> (!stall_o && r_q.ctrl.fault));

    // R10
    frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && bus_wr) |=> ($stable(r_q.page) && $stable(r_q.offs)));
endmodule

// File: tb/tb_nvm_prog_ctrl.sv
module tb_nvm_prog_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ERASE_CYC  = 40;
    localparam int PROG_CYC   = 12;
    localparam int NVEC       = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [2:0]  bus_sel;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        stall_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_prog_ctrl #(
        .ERASE_CYCLES (ERASE_CYC),
        .PROG_CYCLES  (PROG_CYC)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stall_o   (stall_o)
    );

    typedef struct packed {
        logic [7:0]  k1;
        logic [7:0]  k2;
        logic        mid;
        logic [15:0] ctl;
        logic        go;
        logic [7:0]  dur;
        logic        err;
    } vec_t;

    // unlock / start vectors for R2, R3, R4, R8
    localparam vec_t VECS [NVEC] = '{
        '{8'h55, 8'hAA, 1'b0, 16'h8041, 1'b1, 8'(PROG_CYC),  1'b0},
        '{8'hAA, 8'h55, 1'b0, 16'h8041, 1'b0, 8'd0,          1'b0},
        '{8'h55, 8'h55, 1'b0, 16'h8041, 1'b0, 8'd0,          1'b0},
        '{8'h55, 8'hAA, 1'b1, 16'h8041, 1'b0, 8'd0,          1'b0},
        '{8'h55, 8'hAA, 1'b0, 16'h8001, 1'b0, 8'd0,          1'b0},
        '{8'h55, 8'hAA, 1'b0, 16'h8042, 1'b0, 8'd0,          1'b1},
        '{8'h55, 8'hAA, 1'b0, 16'hC042, 1'b1, 8'(ERASE_CYC), 1'b0},
        '{8'h55, 8'hAA, 1'b0, 16'h0041, 1'b0, 8'd0,          1'b0},
        '{8'h55, 8'hAA, 1'b0, 16'h8043, 1'b0, 8'd0,          1'b1},
        '{8'h12, 8'hAA, 1'b0, 16'h8041, 1'b0, 8'd0,          1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        bus_sel   = sel;
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
    endtask

    task automatic start_op(input logic [15:0] ctl);
        wr(3'd1, 16'h0055);
        wr(3'd1, 16'h00AA);
        wr(3'd0, ctl);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (stall_o === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int n;
        rst_n = 1'b0; bus_wr = 1'b0; bus_sel = 3'd0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", 32'(v), 32'h0);
        check("R1 stall", 32'(stall_o), 32'h0);
        rd(3'd4, v); check("R1 word 0", 32'(v), 32'hFFFF);
        wr(3'd2, 16'h0003); wr(3'd3, 16'h00FF);
        rd(3'd4, v); check("R1 last word", 32'(v), 32'hFFFF);

        // vector walk: R2 R3 R4 R5 R8
        wr(3'd2, 16'h0002); wr(3'd3, 16'h0000);
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd1, {8'h00, VECS[i].k1});
            wr(3'd1, {8'h00, VECS[i].k2});
            if (VECS[i].mid) wr(3'd2, 16'h0002);
            wr(3'd0, VECS[i].ctl);
            check($sformatf("R2/R3/R4 vec%0d stall", i), 32'(stall_o), 32'(VECS[i].go));
            rd(3'd0, v);
            check($sformatf("R2 vec%0d start bit", i), 32'(v[15]), 32'(VECS[i].go));
            if (VECS[i].go) begin
                wait_idle(n);
                check($sformatf("R5 vec%0d duration", i), 32'(n), 32'(VECS[i].dur));
            end
            rd(3'd0, v);
            check($sformatf("R5 vec%0d start cleared", i), 32'(v[15]), 32'h0);
            check($sformatf("R8 vec%0d fault", i), 32'(v[13]), 32'(VECS[i].err));
        end

        // R11 / R6: load buffer, program row 6 via offset with nonzero low bits
        wr(3'd2, 16'h0001);
        for (int i = 0; i < 64; i++) begin
            wr(3'd3, 16'(i));
            wr(3'd4, 16'hA000 + 16'(i));
        end
        wr(3'd3, 16'h0085);
        start_op(16'h8041);
        wait_idle(n);
        check("R5 program duration", 32'(n), 32'(PROG_CYC));
        for (int i = 0; i < 64; i++) begin
            wr(3'd3, 16'h0080 + 16'(i));
            rd(3'd4, v);
            check($sformatf("R6 R11 row word %0d", i), 32'(v), 32'hA000 + 32'(i));
        end
        wr(3'd3, 16'h007F); rd(3'd4, v); check("R6 row below untouched", 32'(v), 32'hFFFF);
        wr(3'd3, 16'h00C0); rd(3'd4, v); check("R6 row above untouched", 32'(v), 32'hFFFF);

        // R9: reprogram same row with no buffer writes
        wr(3'd3, 16'h0080);
        start_op(16'h8041);
        wait_idle(n);
        rd(3'd4, v); check("R9 first word after stale program", 32'(v), 32'hFFFF);
        wr(3'd3, 16'h00BF); rd(3'd4, v); check("R9 last word after stale program", 32'(v), 32'hFFFF);

        // R7: data in block 0 and block 1, erase block 0
        wr(3'd2, 16'h0000); wr(3'd3, 16'h0000); wr(3'd4, 16'h1234);
        start_op(16'h8041); wait_idle(n);
        wr(3'd2, 16'h0002); wr(3'd3, 16'h0000); wr(3'd4, 16'h5678);
        start_op(16'h8041); wait_idle(n);
        wr(3'd2, 16'h0000); rd(3'd4, v); check("R7 setup block0", 32'(v), 32'h1234);
        wr(3'd3, 16'h0093);
        start_op(16'hC042);
        wr(3'd2, 16'h0003);  // R10: write early in the stall
        wait_idle(n);
        check("R5 erase duration", 32'(n - 0 + 1), 32'(ERASE_CYC));
        rd(3'd2, v); check("R10 page held during stall", 32'(v), 32'h0000);
        wr(3'd3, 16'h0000); rd(3'd4, v); check("R7 block0 erased", 32'(v), 32'hFFFF);
        wr(3'd2, 16'h0002); rd(3'd4, v); check("R7 block1 kept", 32'(v), 32'h5678);

        // R10: write landing on the final stalled edge, erase block 1
        start_op(16'hC042);
        repeat (ERASE_CYC - 1) @(negedge clk);
        wr(3'd2, 16'h0003);
        check("R10 stall ended", 32'(stall_o), 32'h0);
        rd(3'd2, v); check("R10 last-cycle write dropped", 32'(v), 32'h0002);
        rd(3'd4, v); check("R7 block1 erased", 32'(v), 32'hFFFF);
        wr(3'd2, 16'h0003);
        rd(3'd2, v); check("R10 write accepted after stall", 32'(v), 32'h0003);

        finish_run();
    end
endmodule